// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers four event signals from a FIFO-based peripheral (read FIFO full, write FIFO empty, read FIFO half full, write FIFO half full) and turns them into a single interrupt request. A rising edge on an event line sets a sticky status bit. Software can enable or mask each status bit, and a separate global enable gates every source at once.

Software reaches the block through a plain 32-bit register port: a write strobe, an address, write data and combinational read data. The status register has toggle-on-write behaviour: writing 1 to a bit inverts it, and writing 0 leaves it alone. Software clears a pending bit by writing back the value it read. The interrupt line is registered. A synchronous clear input from the surrounding control logic empties all three registers without a bus access.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After the asynchronous reset, every readable register reads 0 and `irq_o` is 0.
- R2: A 0-to-1 transition on `evt_in[i]` sets status bit i in the next clock edge. Holding the line high does not set the bit again once it has been cleared. The bit map is: bit 3 read FIFO full, bit 2 write FIFO empty, bit 1 read FIFO half full, bit 0 write FIFO half full.
- R3: A write to the status register (offset 0x20) inverts each of bits 3..0 for which `wdata` holds 1. Bits with `wdata` 0 are unchanged.
- R4: If a status write and an event rising edge hit the same bit in the same cycle, that bit ends at 1.
- R5: A write to the enable register (offset 0x28) loads bits 3..0 from `wdata[3:0]`, so 1 enables a source and 0 masks it. The enable register uses the same bit map as status.
- R6: A write to the global enable register (offset 0x1C) loads its only bit from `wdata[31]`. The register reads back that bit at position 31.
- R7: `irq_o` equals global enable AND the OR over i of (status[i] AND enable[i]). It is registered, so it follows its cause by one clock edge.
- R8: Unimplemented bits of the three registers read as 0, and reads of any other offset return 0.
- R9: `soft_clr` high at a clock edge clears status, enable, global enable and `irq_o`. It wins over a write or an event in the same cycle.
- R10: Writes to offsets other than 0x1C, 0x20 and 0x28 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| soft_clr | input | 1 | Synchronous clear of all registers |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Byte offset of the register access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| evt_in | input | NUM_SRC (4) | Event lines; a rising edge sets status |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, 32-bit data and four sources. With these values the exact offsets 0x1C, 0x20 and 0x28 can be hit, along with a neighbouring unmapped offset 0x24. All four bit positions can be exercised, including bit 31 as the only live global-enable bit. The vectors walk toggle-on-write against sustained event levels, the same-cycle conflict between an event and a toggle, and masking by both the per-source enable and the global enable. Directed tests cover clear priority and reset in the middle of a run.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 4;
  localparam int DATA_W   = 32;
  localparam int GIE_BIT  = 31;
  localparam int OFF_GIE  = 'h1C;
  localparam int OFF_STS  = 'h20;
  localparam int OFF_EN   = 'h28;
  // source bit positions, shared by status and enable
  localparam int SRC_WR_HALF = 0;
  localparam int SRC_RD_HALF = 1;
  localparam int SRC_WR_EMPTY = 2;
  localparam int SRC_RD_FULL = 3;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] evt_q;
  logic [N-1:0] evt_d;

  always_comb begin
    evt_d = evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rise
      assign rise_o[g] = evt_i[g] & ~evt_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [N-1:0] wbits_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;
  logic [N-1:0] sts_d;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      always_comb begin
        sts_d[g] = sts_q[g];
        if (wr_i)     sts_d[g] = sts_q[g] ^ wbits_i[g];
        if (rise_i[g]) sts_d[g] = 1'b1;
        if (clr_i)    sts_d[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i && !clr_i) |=> ((sts_q & $past(rise_i)) == $past(rise_i))); // R4
  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !wr_i && rise_i == '0) |=> $stable(sts_q)); // R3
  AST_STS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sts_q == '0)); // R9
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wbits_i,
  input  logic         gie_we_i,
  input  logic         gie_wbit_i,
  output logic [N-1:0] en_o,
  output logic         gie_o
);
  logic [N-1:0] en_q, en_d;
  logic         gie_q, gie_d;

  always_comb begin
    en_d  = en_q;
    gie_d = gie_q;
    if (en_we_i)  en_d  = en_wbits_i;
    if (gie_we_i) gie_d = gie_wbit_i;
    if (clr_i) begin
      en_d  = '0;
      gie_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      gie_q <= gie_d;
    end
  end

  assign en_o  = en_q;
  assign gie_o = gie_q;

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (en_q == '0 && !gie_q)); // R9
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_we_i && !gie_we_i) |=> ($stable(en_q) && $stable(gie_q))); // R10
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         gie_i,
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q, irq_d;
  logic any_src;

  assign any_src = |(sts_i & en_i);

  always_comb begin
    irq_d = gie_i & any_src;
    if (clr_i) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(gie_i)); // R7
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !irq_q); // R9
endmodule

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = irq_pkg::DATA_W,
  parameter int NUM_SRC = irq_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               irq_o
);
  import irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_GIE = ADDR_W'(OFF_GIE);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_EN);

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] sts;
  logic [NUM_SRC-1:0] en;
  logic               gie;
  logic               we_gie, we_sts, we_en;
  logic               wdata_unused;

  assign we_gie = wr_en && (addr == A_GIE);
  assign we_sts = wr_en && (addr == A_STS);
  assign we_en  = wr_en && (addr == A_EN);
  assign wdata_unused = ^wdata[GIE_BIT-1:NUM_SRC];

  irq_edge_detect #(.N(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_in), .rise_o(rise)
  );

  irq_status_bank #(.N(NUM_SRC)) u_sts (
    .clk(clk), .rst_n(rst_n), .clr_i(soft_clr), .wr_i(we_sts),
    .wbits_i(wdata[NUM_SRC-1:0]), .rise_i(rise), .sts_o(sts)
  );

  irq_enable_regs #(.N(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .clr_i(soft_clr),
    .en_we_i(we_en), .en_wbits_i(wdata[NUM_SRC-1:0]),
    .gie_we_i(we_gie), .gie_wbit_i(wdata[GIE_BIT]),
    .en_o(en), .gie_o(gie)
  );

  irq_out_reg #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr_i(soft_clr),
    .gie_i(gie), .sts_i(sts), .en_i(en), .irq_o(irq_o)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_GIE:   rdata[GIE_BIT] = gie;
      A_STS:   rdata[NUM_SRC-1:0] = sts;
      A_EN:    rdata[NUM_SRC-1:0] = en;
      default: rdata = '0;
    endcase
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && |(sts & en) && !soft_clr) |=> irq_o); // R7
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise && !soft_clr) |=> ((sts & $past(rise)) == $past(rise))); // R2
endmodule

// File: tb/irq_toggle_ctrl_bench.sv
module irq_toggle_ctrl_bench;
  localparam int NV = 13;
  // {wr, addr, wdata, evt, chk_addr, exp_rdata, exp_irq}
  localparam logic [85:0] VEC [NV] = '{
    {1'b1, 8'h28, 32'hFFFF_FFFF, 4'h0, 8'h28, 32'h0000_000F, 1'b0},
    {1'b1, 8'h1C, 32'hFFFF_FFFF, 4'h0, 8'h1C, 32'h8000_0000, 1'b0},
    {1'b0, 8'h00, 32'h0000_0000, 4'h1, 8'h20, 32'h0000_0001, 1'b1},
    {1'b1, 8'h20, 32'h0000_0001, 4'h1, 8'h20, 32'h0000_0000, 1'b0},
    {1'b0, 8'h00, 32'h0000_0000, 4'h9, 8'h20, 32'h0000_0008, 1'b1},
    {1'b1, 8'h20, 32'h0000_0000, 4'h9, 8'h20, 32'h0000_0008, 1'b1},
    {1'b1, 8'h28, 32'h0000_0007, 4'h9, 8'h28, 32'h0000_0007, 1'b0},
    {1'b1, 8'h20, 32'hFFFF_FFF6, 4'h9, 8'h20, 32'h0000_000E, 1'b1},
    {1'b1, 8'h1C, 32'h7FFF_FFFF, 4'h9, 8'h1C, 32'h0000_0000, 1'b0},
    {1'b1, 8'h24, 32'hFFFF_FFFF, 4'h9, 8'h20, 32'h0000_000E, 1'b0},
    {1'b0, 8'h00, 32'h0000_0000, 4'h9, 8'h24, 32'h0000_0000, 1'b0},
    {1'b1, 8'h20, 32'h0000_0004, 4'hD, 8'h20, 32'h0000_000E, 1'b0},
    {1'b1, 8'h1C, 32'h8000_0000, 4'hD, 8'h1C, 32'h8000_0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_clr;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  evt_in;
  logic        irq_o;
  int          n_checks = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  irq_toggle_ctrl u_irq_toggle_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq_o(irq_o)
  );

  function automatic string vec_tag(int i);
    case (i)
      0: return "R5 enable load";
      1: return "R6 global enable bit 31";
      2: return "R2 event edge sets, R7 irq";
      3: return "R3 toggle clears, R2 held level no reset";
      4: return "R2 second edge";
      5: return "R3 zero write keeps";
      6: return "R5 mask, R7 irq drops";
      7: return "R3 toggle sets bits, R8 high bits ignored";
      8: return "R6 global off, R7";
      9: return "R10 unmapped write";
      10: return "R8 unmapped read";
      11: return "R4 event beats toggle";
      default: return "R7 global on again";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic read_chk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic idle_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; soft_clr = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0; evt_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    read_chk("R1 global after reset", 8'h1C, 32'h0);
    read_chk("R1 status after reset", 8'h20, 32'h0);
    read_chk("R1 enable after reset", 8'h28, 32'h0);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    idle_cycle();

    for (int i = 0; i < NV; i++) begin
      logic [85:0] v;
      v = VEC[i];
      wr_en  = v[85];
      addr   = v[84:77];
      wdata  = v[76:45];
      evt_in = v[44:41];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      read_chk(vec_tag(i), v[40:33], v[32:1]);
      idle_cycle();
      check({vec_tag(i), " irq"}, {31'b0, irq_o}, {31'b0, v[0]});
    end

    // R9: clear wins over same-cycle enable write; level stays high
    soft_clr = 1'b1; wr_en = 1'b1; addr = 8'h28; wdata = 32'hF;
    @(posedge clk);
    @(negedge clk);
    soft_clr = 1'b0; wr_en = 1'b0;
    check("R9 irq after clear", {31'b0, irq_o}, 32'h0);
    read_chk("R9 enable after clear", 8'h28, 32'h0);
    read_chk("R9 global after clear", 8'h1C, 32'h0);
    read_chk("R9 status after clear", 8'h20, 32'h0);
    idle_cycle();
    read_chk("R9 R2 held events no re-set", 8'h20, 32'h0);

    // R9: clear beats a rising event in the same cycle
    evt_in = 4'h0;
    idle_cycle();
    evt_in = 4'h2; soft_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    soft_clr = 1'b0;
    read_chk("R9 clear beats event", 8'h20, 32'h0);

    // R4 on bit 3 with all others quiet: toggle write on 0 bit plus edge
    evt_in = 4'h0;
    idle_cycle();
    evt_in = 4'h8; wr_en = 1'b1; addr = 8'h20; wdata = 32'h8;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    read_chk("R4 event plus toggle on clear bit", 8'h20, 32'h8);

    // R1 mid-run reset
    evt_in = 4'h0;
    wr_en = 1'b1; addr = 8'h28; wdata = 32'hF;
    idle_cycle();
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    read_chk("R1 status in reset", 8'h20, 32'h0);
    read_chk("R1 enable in reset", 8'h28, 32'h0);
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    idle_cycle();
    rst_n = 1'b1;
    idle_cycle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
      $finish;
    end
  end
endmodule